// File: doc/BRIEF.md
# Ramp and Tracking Converter Controller

This block is the digital half of a counter-based analog-to-digital converter. It owns a code counter that drives an external DAC, and it reads back a single comparator bit that is high whenever the DAC output is above the analog input. The comparator bit is asynchronous to the block. It passes through a flop synchronizer before any decision uses it.

In ramp mode, a start pulse clears the counter. The counter then climbs one code per clock, so the DAC produces a staircase. The conversion ends at the first code that the comparator reports as above the input. The result is the largest code not above the input, and a one-cycle done pulse announces it. Because the ramp runs from zero every time, the conversion takes longer for larger inputs. If even the top code does not trip the comparator, the conversion ends with an all-ones result and an over-range flag.

In tracking mode, the same counter moves up or down by one code on every clock, following a slowly varying input. It starts from the code it already holds and clamps at both ends of the code range.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While reset is held and just after it is released, dac_code_o, result_o, done_o and over_range_o are all zero.
- R2: With track_i low and no conversion running, a high start_i clears dac_code_o to 0 at the next clock. The code then rises by exactly one per clock while the conversion runs.
- R3: For an input level V in codes (the comparator is high exactly when dac_code_o > V), with 0 <= V < 2^WIDTH-1, the conversion ends with result_o = V. done_o is high for exactly one cycle, rising V + SYNC_STAGES + 2 clock edges after the edge that accepted start. The conversion time therefore grows with V.
- R4: If code 2^WIDTH-1 does not trip the comparator, the conversion ends with result_o all ones and over_range_o high. done_o rises 2^WIDTH-1 + SYNC_STAGES + 1 edges after the accepting edge.
- R5: After done, result_o and over_range_o hold their values until the next conversion. A new start repeats the conversion from code 0, and over_range_o reads 0 after a conversion that tripped normally.
- R6: A start_i pulse during a running conversion is ignored. The conversion finishes with the same result and timing as if no pulse had arrived.
- R7: With track_i high, dac_code_o steps by at most one per clock. It goes down when the synchronized comparator is high and up when it is low, starting from the held code rather than from zero. For a steady V it settles within V-SYNC_STAGES to V+SYNC_STAGES+1.
- R8: In tracking mode, dac_code_o saturates at 0 and at 2^WIDTH-1 and never wraps.
- R9: In tracking mode, start_i has no effect and done_o stays low. Raising track_i during a conversion abandons it without a done pulse.
- R10: In tracking mode, result_o equals the dac_code_o value of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a ramp conversion (sampled when idle) |
| track_i | input | 1 | 1 selects tracking mode, 0 ramp mode |
| cmp_above_i | input | 1 | Asynchronous comparator: DAC output above the analog input |
| dac_code_o | output | WIDTH | Code driven to the external DAC |
| result_o | output | WIDTH | Conversion result; in tracking mode, the previous code |
| done_o | output | 1 | One-cycle pulse at the end of a ramp conversion |
| over_range_o | output | 1 | Last ramp ended at full scale without a trip |

## Verification
The checker watches the cycle-level invariants on every cycle:
- the single-cycle done pulse;
- the clear of the code at an accepted start;
- the monotonic climb during a ramp;
- the one-step motion and clamping while tracking;
- the one-cycle mirroring of the code into result_o;
- the all-ones result whenever the over-range flag is raised.

Only the directed scenarios can show the things that depend on the analog side:
- that the result equals the input level;
- that the done latency grows exactly with that level through the synchronizer;
- that a stray start changes nothing;
- that tracking settles into its window around the input.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAMP  = 2'd1,
    ST_TRACK = 2'd2
  } ctl_state_e;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_UP    = 2'd2,
    OP_DOWN  = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/adc_sync_chain.sv
module adc_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb pipe_d = d_i;
    end else begin : g_many
      always_comb pipe_d = {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/adc_code_delay.sv
// Carries each driven code, tagged valid, alongside the synchronizer so
// the FSM knows which code the current comparator bit belongs to.
module adc_code_delay #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] code_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] code_o
);

  logic [WIDTH-1:0] code_q [STAGES];
  logic [WIDTH-1:0] code_d [STAGES];
  logic             vld_q  [STAGES];
  logic             vld_d  [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_comb begin
          code_d[i] = code_i;
          vld_d[i]  = clear_i ? 1'b0 : vld_i;
        end
      end else begin : g_body
        always_comb begin
          code_d[i] = code_q[i-1];
          vld_d[i]  = clear_i ? 1'b0 : vld_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          code_q[i] <= '0;
          vld_q[i]  <= 1'b0;
        end else begin
          code_q[i] <= code_d[i];
          vld_q[i]  <= vld_d[i];
        end
      end
    end
  endgenerate

  assign vld_o  = vld_q[STAGES-1];
  assign code_o = code_q[STAGES-1];

endmodule

// File: rtl/adc_step_counter.sv
module adc_step_counter
  import ramp_adc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          op_i,
  output logic [WIDTH-1:0] count_o
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (op_i != OP_HOLD);
    unique case (op_i)
      OP_CLEAR: cnt_d = '0;
      OP_UP:    cnt_d = (cnt_q == TOP) ? cnt_q : cnt_q + 1'b1;
      OP_DOWN:  cnt_d = (cnt_q == '0)  ? cnt_q : cnt_q - 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/adc_ctl_fsm.sv
module adc_ctl_fsm
  import ramp_adc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             track_i,
  input  logic             cmp_s_i,
  input  logic             tap_vld_i,
  input  logic [WIDTH-1:0] tap_code_i,
  input  logic [WIDTH-1:0] count_i,
  output ctl_state_e       state_o,
  output cnt_op_e          op_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o,
  output logic             over_o
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  ctl_state_e       state_q, state_d;
  logic             done_q, done_d;
  logic             over_q, over_d;
  logic [WIDTH-1:0] res_q, res_d;
  logic             res_en;

  always_comb begin
    state_d = state_q;
    op_o    = OP_HOLD;
    done_d  = 1'b0;
    over_d  = over_q;
    res_d   = res_q;
    unique case (state_q)
      ST_IDLE: begin
        if (track_i) begin
          state_d = ST_TRACK;
          over_d  = 1'b0;
        end else if (start_i) begin
          state_d = ST_RAMP;
          op_o    = OP_CLEAR;
          over_d  = 1'b0;
        end
      end
      ST_RAMP: begin
        if (track_i) begin
          state_d = ST_TRACK;
          over_d  = 1'b0;
        end else if (tap_vld_i && cmp_s_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          res_d   = (tap_code_i == '0) ? '0 : tap_code_i - 1'b1;
        end else if (tap_vld_i && (tap_code_i == TOP)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          over_d  = 1'b1;
          res_d   = TOP;
        end else begin
          op_o = OP_UP;
        end
      end
      ST_TRACK: begin
        if (!track_i) begin
          state_d = ST_IDLE;
        end else begin
          op_o  = cmp_s_i ? OP_DOWN : OP_UP;
          res_d = count_i;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    res_en = (res_d != res_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      over_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      over_q  <= over_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign state_o  = state_q;
  assign done_o   = done_q;
  assign over_o   = over_q;
  assign result_o = res_q;

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             track_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o,
  output logic             over_range_o
);

  logic [1:0]       rst_pipe_q;
  logic             core_rst_n;
  logic             cmp_s;
  logic             tap_vld;
  logic [WIDTH-1:0] tap_code;
  logic [WIDTH-1:0] count;
  ctl_state_e       ctl_state;
  cnt_op_e          cnt_op;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  adc_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d_i   (cmp_above_i),
    .q_o   (cmp_s)
  );

  adc_code_delay #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_delay (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .clear_i (cnt_op == OP_CLEAR),
    .vld_i   (ctl_state == ST_RAMP),
    .code_i  (count),
    .vld_o   (tap_vld),
    .code_o  (tap_code)
  );

  adc_step_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .op_i    (cnt_op),
    .count_o (count)
  );

  adc_ctl_fsm #(.WIDTH(WIDTH)) u_fsm (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .start_i    (start_i),
    .track_i    (track_i),
    .cmp_s_i    (cmp_s),
    .tap_vld_i  (tap_vld),
    .tap_code_i (tap_code),
    .count_i    (count),
    .state_o    (ctl_state),
    .op_o       (cnt_op),
    .done_o     (done_o),
    .result_o   (result_o),
    .over_o     (over_range_o)
  );

  assign dac_code_o = count;

endmodule

// File: rtl/ramp_adc_ctrl_chk.sv
module ramp_adc_ctrl_chk
  import ramp_adc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             track_i,
  input ctl_state_e       state,
  input logic [WIDTH-1:0] dac_code_o,
  input logic [WIDTH-1:0] result_o,
  input logic             done_o,
  input logic             over_range_o
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  // R3
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  start_clears_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_i && !track_i) |=> (dac_code_o == '0));

  // R2
  ramp_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RAMP && !track_i) |=> (dac_code_o >= $past(dac_code_o)));

  // R4
  over_means_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_range_o |-> (result_o == TOP));

  // R7
  track_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRACK) |=> ((dac_code_o == $past(dac_code_o)) ||
                             (dac_code_o == $past(dac_code_o) + 1'b1) ||
                             (dac_code_o == $past(dac_code_o) - 1'b1)));

  // R8
  track_no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRACK && dac_code_o == TOP) |=> (dac_code_o != '0));

  // R8
  track_no_wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRACK && dac_code_o == '0) |=> (dac_code_o != TOP));

  // R9
  track_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRACK) |=> !done_o);

  // R10
  track_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRACK && track_i) |=> (result_o == $past(dac_code_o)));

endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .track_i      (track_i),
  .state        (ctl_state),
  .dac_code_o   (dac_code_o),
  .result_o     (result_o),
  .done_o       (done_o),
  .over_range_o (over_range_o)
);

// File: tb/ramp_adc_ctrl_bench.sv
module ramp_adc_ctrl_bench;

  localparam int W      = 8;
  localparam int SYNC   = 2;
  localparam int TOPV   = (1 << W) - 1;
  localparam int CLK_NS = 10;
  localparam int WD_CYC = 150000;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         track;
  logic         cmp_above;
  logic [W-1:0] dac_code;
  logic [W-1:0] result;
  logic         done;
  logic         over;
  int           vin;
  int           total;
  int           bad;
  int           cyc;

  ramp_adc_ctrl #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_ramp_adc_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .track_i      (track),
    .cmp_above_i  (cmp_above),
    .dac_code_o   (dac_code),
    .result_o     (result),
    .done_o       (done),
    .over_range_o (over)
  );

  // analog side: DAC plus comparator
  always_comb cmp_above = (int'(dac_code) > vin);

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_CYC) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WD_CYC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // runs one ramp; returns cycles counted with the accepting edge as 1
  task automatic run_ramp(input int mid_start_at, output int n_out);
    int n;
    n = 0;
    @(negedge clk) start = 1'b1;
    while (n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = (n == mid_start_at) ? 1'b1 : 1'b0;
      if (done) break;
    end
    start = 1'b0;
    n_out = n;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; track = 1'b0; vin = 0;
    repeat (3) @(negedge clk);
    chk(dac_code == 0 && result == 0 && !done && !over, "R1", "in reset",
        {dac_code, result}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dac_code == 0 && result == 0 && !done && !over, "R1", "after release",
        {dac_code, result}, 0);
  endtask

  task automatic t_ramp_climb();
    int prev;
    vin = 40;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(dac_code == 0, "R2", "code cleared", dac_code, 0);
    prev = 0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk(int'(dac_code) == prev + 1, "R2", "ramp step", dac_code, prev + 1);
      prev = int'(dac_code);
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_ramp(input int level);
    int n;
    vin = level;
    run_ramp(-1, n);
    chk(n == level + SYNC + 3, "R3", "done latency", n, level + SYNC + 3);
    chk(int'(result) == level, "R3", "result", result, level);
    chk(!over, "R5", "no over flag", over, 0);
    @(negedge clk);
    chk(!done, "R3", "done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(int'(result) == level, "R5", "result held", result, level);
  endtask

  task automatic t_over();
    int n;
    vin = 1000;
    run_ramp(-1, n);
    chk(n == TOPV + SYNC + 2, "R4", "over latency", n, TOPV + SYNC + 2);
    chk(int'(result) == TOPV && over, "R4", "over result", result, TOPV);
    repeat (3) @(negedge clk);
    chk(over, "R5", "over flag held", over, 1);
  endtask

  task automatic t_mid_start();
    int n;
    vin = 20;
    run_ramp(10, n);
    chk(n == 20 + SYNC + 3, "R6", "latency with stray start", n, 20 + SYNC + 3);
    chk(int'(result) == 20, "R6", "result with stray start", result, 20);
  endtask

  task automatic t_track_from_held();
    int prev;
    int n;
    vin = 50;
    run_ramp(-1, n);
    @(negedge clk);
    prev = int'(dac_code);
    track = 1'b1;
    @(negedge clk);
    chk(int'(dac_code) == prev, "R7", "first track cycle holds", dac_code, prev);
    @(negedge clk);
    chk(int'(dac_code) == prev - 1, "R7", "steps down from held", dac_code, prev - 1);
    chk(!over, "R5", "over cleared", over, 0);
  endtask

  task automatic t_track_settle(input int level);
    int ok;
    int prev;
    vin = level;
    repeat (300) @(negedge clk);
    ok = 1;
    prev = int'(dac_code);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (int'(dac_code) < level - SYNC || int'(dac_code) > level + SYNC + 1) ok = 0;
      if (int'(result) != prev) begin
        chk(0, "R10", "result mirrors code", result, prev);
      end
      prev = int'(dac_code);
    end
    chk(ok == 1, "R7", "settle window", dac_code, level);
    chk(int'(result) != -1, "R10", "mirror loop ran", result, result);
  endtask

  task automatic t_track_sat(input int level, input int edge_code);
    int ok;
    vin = level;
    repeat (300) @(negedge clk);
    ok = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (int'(dac_code) != edge_code) ok = 0;
    end
    chk(ok == 1, "R8", "saturated code", dac_code, edge_code);
  endtask

  task automatic t_track_start();
    int prev;
    int seen;
    vin = 100;
    repeat (300) @(negedge clk);
    prev = int'(dac_code);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(int'(dac_code) >= prev - 1 && int'(dac_code) <= prev + 1, "R9",
        "start ignored in tracking", dac_code, prev);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen == 0, "R9", "no done while tracking", seen, 0);
    track = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_abort();
    int seen;
    vin = 200;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    track = 1'b1;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen == 0, "R9", "abort gives no done", seen, 0);
    track = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    total = 0;
    bad   = 0;
    cyc   = 0;
    t_reset();
    t_ramp_climb();
    t_ramp(0);
    t_ramp(7);
    t_ramp(130);
    t_ramp(TOPV - 1);
    t_over();
    t_ramp(10);
    t_mid_start();
    t_track_from_held();
    t_track_settle(80);
    t_track_settle(120);
    t_track_sat(1000, TOPV);
    t_track_sat(-1, 0);
    t_track_start();
    t_abort();
    t_ramp(33);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule